// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block runs the memory side of taking an interrupt and of returning from one in a 16-bit segmented core. When an entry request arrives with an 8-bit vector number, it saves three words on a downward-growing stack: the status word, the code segment, and a return offset chosen by the caller. It then masks further interrupts and single-stepping by clearing two status bits. Finally it reads the handler's offset and segment from a table of 4-byte entries that starts at physical address zero. On a return request it reads the three saved words back and restores all of them. Because it restores the saved status word, the two cleared bits go back to their earlier values.

The core supplies its current segment, stack, status and return-offset values together with a one-cycle strobe. The sequencer drives a word-wide memory port, 16 bits over a 20-bit byte address, and moves one word for each cycle in which ready is high. When the last word has landed it pulses done, and the updated register values are valid in that cycle. A fault handler in the core can pass the address of the faulting instruction as the return offset, so the handler returns to it and it runs again.

Top module: `vis_top`

## Requirements
- R1: While reset is held, and until the first request, busy, done, mem_rd and mem_wr are low and every new_* output reads zero.
- R2: On entry, three words are written in this order: the status word at SS*16+(SP-2), the code segment at SS*16+(SP-4), then the return offset at SS*16+(SP-6). SP arithmetic wraps modulo 2^16 and the physical address wraps modulo 2^20.
- R3: The status word written on entry keeps its original bit 9 (interrupt enable) and bit 8 (trap). The status word reported after entry equals the original with bits 9 and 8 cleared and every other bit unchanged.
- R4: After the pushes, entry reads the new IP from the word at physical address 4n and the new CS from the word at 4n+2, where n is the vector number. A word is little-endian: its low byte sits at the even address.
- R5: A return reads IP at SS*16+SP, then CS at SS*16+SP+2, then the status word at SS*16+SP+4. It reports SP+6 and restores the popped status word exactly.
- R6: A table entry that is rewritten between two interrupts takes effect on the next entry that uses that vector.
- R7: A strobe held without ready keeps its address, data and direction unchanged. Reads and writes are never strobed together, and each cycle with ready high completes exactly one access.
- R8: Done is high for exactly one cycle, in the cycle after the last access completes. new_cs, new_ip, new_sp and new_flags are valid then, and an entry reports SP-6.
- R9: A request that arrives while busy is high has no effect. No extra access occurs and the running sequence finishes unchanged.
- R10: If an entry request and a return request arrive in the same idle cycle, the entry sequence is the one carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| entry_req | input | 1 | One-cycle strobe to start an interrupt entry |
| ret_req | input | 1 | One-cycle strobe to start an interrupt return |
| vec_num | input | 8 | Vector number for entry |
| cur_cs | input | 16 | Current code segment |
| cur_ss | input | 16 | Current stack segment |
| cur_sp | input | 16 | Current stack pointer |
| cur_flags | input | 16 | Current status word |
| ret_ip | input | 16 | Offset to save as the return point |
| mem_ready | input | 1 | Memory completes the strobed access this cycle |
| mem_rdata | input | 16 | Read word, little-endian |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 20 | Byte address of the word (even) |
| mem_wdata | output | 16 | Write word |
| new_cs | output | 16 | Updated code segment |
| new_ip | output | 16 | Updated instruction offset |
| new_sp | output | 16 | Updated stack pointer |
| new_flags | output | 16 | Updated status word |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the memory keeps mem_rdata valid for the address on the port whenever it raises ready. They also assume that a request strobe lasts one cycle. The stall-hold property further takes it that ready alone decides whether an access is accepted. The bench drives ready from a fixed pattern, either always high or high one cycle in three, and serves reads combinationally from its own byte array. It keeps the stack regions and the vector table apart, so every expected pop and table word is known when the request is issued.

// File: rtl/vis_pkg.sv
package vis_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_F,
    ST_PUSH_CS,
    ST_PUSH_IP,
    ST_RD_IP,
    ST_RD_CS,
    ST_POP_IP,
    ST_POP_CS,
    ST_POP_F
  } vis_state_e;
endpackage

// File: rtl/vis_phys_addr.sv
module vis_phys_addr #(
  parameter int AW = 20,
  parameter int WW = 16
) (
  input  logic [WW-1:0] seg,
  input  logic [WW-1:0] off,
  output logic [AW-1:0] phys
);
  localparam int SHIFT = 4;
  localparam int SW    = WW + SHIFT;

  logic [SW-1:0] sum;

  // base*16 + offset, truncated to the address width (wraps)
  assign sum  = {seg, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, off};
  assign phys = sum[AW-1:0];
endmodule

// File: rtl/vis_step_ctrl.sv
module vis_step_ctrl
  import vis_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       entry_req,
  input  logic       ret_req,
  input  logic       mem_ready,
  output vis_state_e state,
  output logic       start_entry,
  output logic       start_ret,
  output logic       step,
  output logic       done
);
  vis_state_e state_d;
  logic       last;

  assign start_entry = (state == ST_IDLE) && entry_req;
  assign start_ret   = (state == ST_IDLE) && !entry_req && ret_req;
  assign step        = (state != ST_IDLE) && mem_ready;
  assign last        = step && ((state == ST_RD_CS) || (state == ST_POP_F));

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE: begin
        if (entry_req)    state_d = ST_PUSH_F;
        else if (ret_req) state_d = ST_POP_IP;
      end
      ST_PUSH_F:  if (mem_ready) state_d = ST_PUSH_CS;
      ST_PUSH_CS: if (mem_ready) state_d = ST_PUSH_IP;
      ST_PUSH_IP: if (mem_ready) state_d = ST_RD_IP;
      ST_RD_IP:   if (mem_ready) state_d = ST_RD_CS;
      ST_RD_CS:   if (mem_ready) state_d = ST_IDLE;
      ST_POP_IP:  if (mem_ready) state_d = ST_POP_CS;
      ST_POP_CS:  if (mem_ready) state_d = ST_POP_F;
      ST_POP_F:   if (mem_ready) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_d;
      done  <= last;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_ready)); // R8
endmodule

// File: rtl/vis_top.sv
module vis_top
  import vis_pkg::*;
#(
  parameter int AW = 20,
  parameter int WW = 16,
  parameter int VW = 8,
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          entry_req,
  input  logic          ret_req,
  input  logic [VW-1:0] vec_num,
  input  logic [WW-1:0] cur_cs,
  input  logic [WW-1:0] cur_ss,
  input  logic [WW-1:0] cur_sp,
  input  logic [WW-1:0] cur_flags,
  input  logic [WW-1:0] ret_ip,
  input  logic          mem_ready,
  input  logic [WW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [WW-1:0] mem_wdata,
  output logic [WW-1:0] new_cs,
  output logic [WW-1:0] new_ip,
  output logic [WW-1:0] new_sp,
  output logic [WW-1:0] new_flags,
  output logic          busy,
  output logic          done
);
  localparam int          PAD   = AW - VW - 2;
  localparam logic [WW-1:0] WSTEP = WW'(2);
  localparam logic [WW-1:0] MASK  = ~((WW'(1) << IF_BIT) | (WW'(1) << TF_BIT));

  // reset: asserted at once, released on a clock edge
  logic [1:0] rsync_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  vis_state_e state;
  logic start_entry, start_ret, step;

  vis_step_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (arst_n),
    .entry_req  (entry_req),
    .ret_req    (ret_req),
    .mem_ready  (mem_ready),
    .state      (state),
    .start_entry(start_entry),
    .start_ret  (start_ret),
    .step       (step),
    .done       (done)
  );

  logic [WW-1:0] ss_q, sp_q, cs_q, ip_q, fl_q;
  logic [VW-1:0] vec_q;
  logic          is_entry_q;
  logic          pushing, vec_rd;
  logic [WW-1:0] stk_off;
  logic [AW-1:0] stk_addr, vec_addr;

  assign pushing = (state == ST_PUSH_F) || (state == ST_PUSH_CS) || (state == ST_PUSH_IP);
  assign vec_rd  = (state == ST_RD_IP) || (state == ST_RD_CS);
  assign stk_off = pushing ? (sp_q - WSTEP) : sp_q;

  vis_phys_addr #(.AW(AW), .WW(WW)) u_stk_addr (
    .seg (ss_q),
    .off (stk_off),
    .phys(stk_addr)
  );

  assign vec_addr = {{PAD{1'b0}}, vec_q, (state == ST_RD_CS), 1'b0};

  always_comb begin
    mem_wr    = pushing;
    mem_rd    = (state != ST_IDLE) && !pushing;
    mem_addr  = vec_rd ? vec_addr : stk_addr;
    case (state)
      ST_PUSH_F:  mem_wdata = fl_q;
      ST_PUSH_CS: mem_wdata = cs_q;
      ST_PUSH_IP: mem_wdata = ip_q;
      default:    mem_wdata = '0;
    endcase
  end

  // working registers: clock enable is start or a completed access
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ss_q       <= '0;
      sp_q       <= '0;
      cs_q       <= '0;
      ip_q       <= '0;
      fl_q       <= '0;
      vec_q      <= '0;
      is_entry_q <= 1'b0;
    end else if (start_entry || start_ret) begin
      ss_q       <= cur_ss;
      sp_q       <= cur_sp;
      cs_q       <= cur_cs;
      ip_q       <= ret_ip;
      fl_q       <= cur_flags;
      vec_q      <= vec_num;
      is_entry_q <= start_entry;
    end else if (step) begin
      case (state)
        ST_PUSH_F: begin
          sp_q <= sp_q - WSTEP;
          fl_q <= fl_q & MASK;   // masked only after the old copy is stored
        end
        ST_PUSH_CS, ST_PUSH_IP: sp_q <= sp_q - WSTEP;
        ST_RD_IP:  ip_q <= mem_rdata;
        ST_RD_CS:  cs_q <= mem_rdata;
        ST_POP_IP: begin
          ip_q <= mem_rdata;
          sp_q <= sp_q + WSTEP;
        end
        ST_POP_CS: begin
          cs_q <= mem_rdata;
          sp_q <= sp_q + WSTEP;
        end
        ST_POP_F: begin
          fl_q <= mem_rdata;
          sp_q <= sp_q + WSTEP;
        end
        default: ;
      endcase
    end
  end

  assign new_cs    = cs_q;
  assign new_ip    = ip_q;
  assign new_sp    = sp_q;
  assign new_flags = fl_q;
  assign busy      = (state != ST_IDLE);

  // checker state: stack pointer at the start of the running sequence
  logic [WW-1:0] sp_start_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                      sp_start_q <= '0;
    else if (start_entry || start_ret) sp_start_q <= cur_sp;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    (mem_rd || mem_wr) && !mem_ready |=>
      $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_rd) && $stable(mem_wr)); // R7

  AST_ONE_DIR: assert property (@(posedge clk) disable iff (!arst_n)
    !(mem_rd && mem_wr)); // R7

  AST_ENTRY_MASKED: assert property (@(posedge clk) disable iff (!arst_n)
    done && is_entry_q |-> !new_flags[IF_BIT] && !new_flags[TF_BIT]); // R3

  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!arst_n)
    vec_rd |-> mem_addr[AW-1:VW+2] == '0 && !mem_addr[0]); // R4

  AST_ENTRY_SP: assert property (@(posedge clk) disable iff (!arst_n)
    done && is_entry_q |-> new_sp == sp_start_q - WW'(6)); // R8

  AST_RET_SP: assert property (@(posedge clk) disable iff (!arst_n)
    done && !is_entry_q |-> new_sp == sp_start_q + WW'(6)); // R5

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!arst_n)
    busy && (entry_req || ret_req) |=> $stable(is_entry_q) && $stable(sp_start_q)); // R9
endmodule

// File: tb/vis_top_test.sv
module vis_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        entry_req = 1'b0, ret_req = 1'b0;
  logic [7:0]  vec_num = '0;
  logic [15:0] cur_cs = '0, cur_ss = '0, cur_sp = '0, cur_flags = '0, ret_ip = '0;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        mem_rd, mem_wr, busy, done;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, new_cs, new_ip, new_sp, new_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  vis_top uut (
    .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .ret_req(ret_req),
    .vec_num(vec_num), .cur_cs(cur_cs), .cur_ss(cur_ss), .cur_sp(cur_sp),
    .cur_flags(cur_flags), .ret_ip(ret_ip), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .new_cs(new_cs), .new_ip(new_ip), .new_sp(new_sp),
    .new_flags(new_flags), .busy(busy), .done(done)
  );

  int total = 0;
  int bad   = 0;

  // byte memory model
  logic [7:0] mem [int unsigned];

  function automatic logic [7:0] rd_byte(int unsigned a);
    if (mem.exists(a)) return mem[a];
    return 8'h00;
  endfunction
  function automatic logic [15:0] rd_word(logic [19:0] a);
    return {rd_byte(int'(a) + 1), rd_byte(int'(a))};
  endfunction
  function automatic logic [19:0] phys(logic [15:0] s, logic [15:0] o);
    logic [20:0] t;
    t = {1'b0, s, 4'h0} + {5'h0, o};
    return t[19:0];
  endfunction
  task automatic wr_word(logic [19:0] a, logic [15:0] d);
    mem[int'(a)]     = d[7:0];
    mem[int'(a) + 1] = d[15:8];
  endtask

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference: expected accesses and final register values
  logic [19:0] q_addr [$];
  bit          q_wr   [$];
  logic [15:0] q_data [$];
  string       q_req  [$];
  logic [15:0] e_cs, e_ip, e_sp, e_fl;
  bit want_done = 0, fin = 0, stall = 0, checking = 0;
  int cyc = 0;

  always @(posedge clk) if (mem_wr && mem_ready) wr_word(mem_addr, mem_wdata);

  always @(negedge clk) begin
    cyc++;
    mem_ready = stall ? ((cyc % 3) == 2) : 1'b1;
    mem_rdata = rd_word(mem_addr);
    if (checking) begin
      if (done) begin
        chk(want_done, "R8", "done without completion", 32'(done), 32'(want_done));
        if (want_done) begin
          chk(new_cs == e_cs, "R8", "new_cs", 32'(new_cs), 32'(e_cs));
          chk(new_ip == e_ip, "R8", "new_ip", 32'(new_ip), 32'(e_ip));
          chk(new_sp == e_sp, "R8", "new_sp", 32'(new_sp), 32'(e_sp));
          chk(new_flags == e_fl, "R3", "new_flags", 32'(new_flags), 32'(e_fl));
        end
        want_done = 0;
        fin = 1;
      end else if (want_done) begin
        chk(0, "R8", "done missing", 32'(done), 32'(1));
        want_done = 0;
        fin = 1;
      end
      if ((mem_rd || mem_wr) && mem_ready) begin
        if (q_addr.size() == 0) begin
          chk(0, "R9", "unexpected access", 32'(mem_addr), 32'hFFFFF);
        end else begin
          chk(mem_addr == q_addr[0], q_req[0], "address", 32'(mem_addr), 32'(q_addr[0]));
          chk(mem_wr == q_wr[0], "R7", "direction", 32'(mem_wr), 32'(q_wr[0]));
          if (q_wr[0])
            chk(mem_wdata == q_data[0], q_req[0], "write data", 32'(mem_wdata), 32'(q_data[0]));
          void'(q_addr.pop_front()); void'(q_wr.pop_front());
          void'(q_data.pop_front()); void'(q_req.pop_front());
          if (q_addr.size() == 0) want_done = 1;
        end
      end
    end
  end

  task automatic push_exp(logic [19:0] a, bit w, logic [15:0] d, string r);
    q_addr.push_back(a); q_wr.push_back(w); q_data.push_back(d); q_req.push_back(r);
  endtask

  task automatic plan_entry(logic [7:0] n, logic [15:0] ss, logic [15:0] sp,
                            logic [15:0] cs, logic [15:0] fl, logic [15:0] rip);
    logic [19:0] va;
    va = {10'h0, n, 2'b00};
    push_exp(phys(ss, sp - 16'd2), 1, fl,  "R2");
    push_exp(phys(ss, sp - 16'd4), 1, cs,  "R2");
    push_exp(phys(ss, sp - 16'd6), 1, rip, "R2");
    push_exp(va,         0, 16'h0, "R4");
    push_exp(va + 20'd2, 0, 16'h0, "R4");
    e_ip = rd_word(va);
    e_cs = rd_word(va + 20'd2);
    e_sp = sp - 16'd6;
    e_fl = fl & ~16'h0300;
  endtask

  task automatic plan_ret(logic [15:0] ss, logic [15:0] sp);
    push_exp(phys(ss, sp),          0, 16'h0, "R5");
    push_exp(phys(ss, sp + 16'd2),  0, 16'h0, "R5");
    push_exp(phys(ss, sp + 16'd4),  0, 16'h0, "R5");
    e_ip = rd_word(phys(ss, sp));
    e_cs = rd_word(phys(ss, sp + 16'd2));
    e_fl = rd_word(phys(ss, sp + 16'd4));
    e_sp = sp + 16'd6;
  endtask

  task automatic wait_fin();
    while (!fin) @(negedge clk);
    fin = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_entry(logic [7:0] n, logic [15:0] ss, logic [15:0] sp,
                           logic [15:0] cs, logic [15:0] fl, logic [15:0] rip);
    @(negedge clk);
    vec_num = n; cur_ss = ss; cur_sp = sp; cur_cs = cs; cur_flags = fl; ret_ip = rip;
    plan_entry(n, ss, sp, cs, fl, rip);
    entry_req = 1;
    @(negedge clk);
    entry_req = 0;
    wait_fin();
  endtask

  task automatic run_ret(logic [15:0] ss, logic [15:0] sp);
    @(negedge clk);
    cur_ss = ss; cur_sp = sp;
    plan_ret(ss, sp);
    ret_req = 1;
    @(negedge clk);
    ret_req = 0;
    wait_fin();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // vector table contents
    wr_word(20'h00084, 16'h1234); wr_word(20'h00086, 16'hA000);   // vector 0x21
    wr_word(20'h00000, 16'h0BAD); wr_word(20'h00002, 16'hF000);   // vector 0
    wr_word(20'h003FC, 16'h5A5A); wr_word(20'h003FE, 16'hC3C3);   // vector 0xFF

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
    chk(!mem_rd && !mem_wr, "R1", "strobes in reset", {mem_rd, mem_wr}, 0);
    chk(new_sp == 0 && new_ip == 0, "R1", "regs in reset", {new_sp, new_ip}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!busy && !mem_rd && !mem_wr, "R1", "idle after release", {busy, mem_rd, mem_wr}, 0);
    checking = 1;

    // R2 R3 R4: entry with both IF and TF set, no stalls
    run_entry(8'h21, 16'h2000, 16'h0100, 16'h1111, 16'h0346, 16'h7777);
    // R5: return restores the pushed words
    run_ret(16'h2000, 16'h00FA);
    chk(new_flags == 16'h0346, "R5", "restored IF/TF", 32'(new_flags), 32'h0346);

    // R7: stalled memory, highest vector
    stall = 1;
    run_entry(8'hFF, 16'h3000, 16'h8000, 16'h2222, 16'hFFFF, 16'h4444);
    run_ret(16'h3000, 16'h7FFA);
    stall = 0;

    // R6: rewrite vector 0x21 and take it again
    wr_word(20'h00084, 16'h9876); wr_word(20'h00086, 16'hB800);
    run_entry(8'h21, 16'h2000, 16'h0200, 16'h1111, 16'h0000, 16'h0042);
    chk(new_ip == 16'h9876 && new_cs == 16'hB800, "R6", "updated vector", {new_cs, new_ip},
        32'hB8009876);

    // R2: SP and physical address wrap, fault-style return offset
    run_entry(8'h00, 16'hFFFF, 16'h0002, 16'h5555, 16'h0100, 16'h0033);
    run_ret(16'hFFFF, 16'hFFFC);

    // R9: requests during a running entry are ignored
    @(negedge clk);
    vec_num = 8'hFF; cur_ss = 16'h4000; cur_sp = 16'h1000; cur_cs = 16'h6666;
    cur_flags = 16'h0200; ret_ip = 16'h0010;
    plan_entry(8'hFF, 16'h4000, 16'h1000, 16'h6666, 16'h0200, 16'h0010);
    entry_req = 1;
    @(negedge clk);
    entry_req = 0;
    @(negedge clk);
    ret_req = 1; entry_req = 1; vec_num = 8'h00; cur_sp = 16'h3333;
    @(negedge clk);
    ret_req = 0; entry_req = 0;
    wait_fin();
    repeat (6) @(negedge clk);
    chk(!busy, "R9", "idle after ignored request", 32'(busy), 0);

    // R10: both requests in the same idle cycle, entry wins
    @(negedge clk);
    vec_num = 8'h21; cur_ss = 16'h5000; cur_sp = 16'h0400; cur_cs = 16'h7070;
    cur_flags = 16'h0101; ret_ip = 16'h0202;
    plan_entry(8'h21, 16'h5000, 16'h0400, 16'h7070, 16'h0101, 16'h0202);
    entry_req = 1; ret_req = 1;
    @(negedge clk);
    entry_req = 0; ret_req = 0;
    wait_fin();
    chk(q_addr.size() == 0, "R10", "leftover accesses", q_addr.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule